// File: doc/BRIEF.md
# USB Device Interrupt Status Logic

This block keeps the interrupt request flags of a small USB device controller and drives a single level interrupt toward the CPU. There are five flags: receive done, transmit done, suspend, resume and host reset. Each flag is set by a decoded event from the endpoints or from the bus when its mask bit is 0. Software clears a flag only by writing a 1 to its bit.

The block also contains the bus-idle timer. This timer raises the suspend flag once per idle period and enters the suspended state. The suspended state lets resume signalling be recognised, and a resume or a host reset ends it.

A host-initiated bus reset returns the rest of the controller to its reset state, but the host-reset flag keeps its value, so software can still see afterwards that the reset occurred. The system reset, which is separate from the host reset, clears everything.

Top module: `usb_irq_status`

## Requirements
- R1: Flag bit 0 (receive done) becomes 1 on the clock edge where `rx_pkt_done` is 1 and `irq_mask[0]` is 0. It never sets while `irq_mask[0]` is 1.
- R2: Flag bit 1 (transmit done) becomes 1 on the clock edge where `tx_pkt_done` is 1 and `irq_mask[1]` is 0. It never sets while `irq_mask[1]` is 1.
- R3: A write with `reg_wr`=1 clears exactly the flags whose `reg_wdata` bit is 1. Bits written as 0 keep their value. When a set condition and a clear of the same bit fall in the same cycle, the bit ends up 1.
- R4: With `bus_idle` held at 1, flag bit 2 (suspend) sets on the edge that ends idle cycle number CLK_KHZ*IDLE_MS+1, and not earlier, provided `irq_mask[2]` is 0. It fires only once per unbroken idle period, and any cycle with `bus_idle`=0 restarts the count.
- R5: `dev_suspended` becomes 1 on that same timeout edge, whatever the mask. It returns to 0 on the edge after `resume_seen` or `host_reset` is 1.
- R6: Flag bit 3 (resume) sets only when `irq_mask[3]` is 0, `dev_suspended` is 1 and `resume_seen` is 1.
- R7: On `host_reset`, flag bit 4 (host reset) sets if `irq_mask[4]` is 0 and otherwise keeps its value. Flag bits 3..0, the suspended state and the idle count are cleared.
- R8: `irq` is 1 exactly while at least one flag bit is 1.
- R9: A low `rst_n` at a clock edge clears all five flags, including bit 4, and also clears `dev_suspended` and the idle count.
- R10: `reg_rdata` presents the five flags at bits 0 (receive), 1 (transmit), 2 (suspend), 3 (resume) and 4 (host reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| irq_mask | input | 5 | Per-flag mask, 1 blocks setting |
| rx_pkt_done | input | 1 | OUT endpoint finished receiving a packet (pulse) |
| tx_pkt_done | input | 1 | IN endpoint finished sending a packet (pulse) |
| bus_idle | input | 1 | Bus shows no activity this cycle |
| resume_seen | input | 1 | Resume signalling detected |
| host_reset | input | 1 | Host bus reset detected |
| reg_wr | input | 1 | Write strobe for the flag register |
| reg_wdata | input | 5 | Write data, 1 clears the flag |
| reg_rdata | output | 5 | Current flag values |
| dev_suspended | output | 1 | Device is in the suspended state |
| irq | output | 1 | Level interrupt, OR of all flags |

## Verification
The bench builds the block with CLK_KHZ=4 and IDLE_MS=3, so the idle threshold is 13 cycles instead of many thousands. With that setting the bench can hold the bus idle for exactly one cycle short of the timeout and for exactly the timeout, and then keep it idle well past the timeout to show that the suspend flag fires only once. The same short threshold makes it cheap to re-enter suspend several times. This lets the bench try resume while masked, while unmasked and while not suspended, and try a host reset both with and without the suspended state active.

// File: rtl/usbint_pkg.sv
// Shared constants for the USB interrupt status logic: flag count and bit positions.
// Assumes software and the bench use these bit positions for the flag register.
package usbint_pkg;
    localparam int unsigned NFLAG   = 5;
    localparam int unsigned FL_RX   = 0;
    localparam int unsigned FL_TX   = 1;
    localparam int unsigned FL_SUSP = 2;
    localparam int unsigned FL_RES  = 3;
    localparam int unsigned FL_HRST = 4;
endpackage

// File: rtl/usbint_idle_timer.sv
// Counts consecutive idle bus cycles and pulses 'timeout' once, on the cycle
// the count reaches LIMIT. The count saturates, so there is one pulse per idle period.
// Assumes bus_idle is synchronous to clk; 'restart' (host reset) clears the count.
module usbint_idle_timer #(
    parameter int unsigned LIMIT = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    input  logic restart,
    output logic timeout
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Idle counter: clears on activity or restart, saturates at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !bus_idle) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pulse on the edge that moves the count onto LIMIT.
    assign timeout = bus_idle && !restart && (cnt_q == LAST_V);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_V);                                                     // R4
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);                                               // R4
    AST_ACTIVITY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |=> !timeout);                                             // R4
endmodule

// File: rtl/usbint_susp_state.sv
// Tracks whether the device is suspended: it enters on the idle timeout and
// leaves on resume signalling or on a host reset, and leaving wins over entering.
// Assumes timeout is a single-cycle pulse from the idle timer.
module usbint_susp_state (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic resume_seen,
    input  logic host_reset,
    output logic suspended
);
    logic susp_q;

    // Suspended state register.
    always_ff @(posedge clk) begin
        if (!rst_n || resume_seen || host_reset) begin
            susp_q <= 1'b0;
        end else if (timeout) begin
            susp_q <= 1'b1;
        end
    end

    assign suspended = susp_q;

    AST_SUSP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_seen || host_reset) |=> !susp_q);                            // R5
    AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!susp_q && !timeout) |=> !susp_q);                                  // R5
endmodule

// File: rtl/usbint_flags.sv
// Holds the interrupt request flags. A flag sets on its qualified event when
// its mask bit is 0 and clears on a write of 1; when both happen in one cycle, the set wins.
// A host reset clears every flag except the host-reset flag.
module usbint_flags
    import usbint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] mask,
    input  logic             rx_done,
    input  logic             tx_done,
    input  logic             timeout,
    input  logic             suspended,
    input  logic             resume_seen,
    input  logic             host_reset,
    input  logic             wr_en,
    input  logic [NFLAG-1:0] wr_data,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] raw_evt;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] flags_q;

    // Gather the raw set events per flag position.
    always_comb begin
        raw_evt          = '0;
        raw_evt[FL_RX]   = rx_done;
        raw_evt[FL_TX]   = tx_done;
        raw_evt[FL_SUSP] = timeout;
        raw_evt[FL_RES]  = resume_seen && suspended;
        raw_evt[FL_HRST] = host_reset;
    end

    assign set_v = raw_evt & ~mask;
    assign clr_v = wr_en ? wr_data : '0;

    // Per-bit flag register; set wins over clear, a host reset wipes the non-reset flags.
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (host_reset && (i != FL_HRST)) begin
                flags_q[i] <= 1'b0;
            end else if (set_v[i]) begin
                flags_q[i] <= 1'b1;
            end else if (clr_v[i]) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    assign flags = flags_q;

    AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[FL_RX] && !flags_q[FL_RX]) |=> !flags_q[FL_RX]);               // R1
    AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[FL_TX] && !flags_q[FL_TX]) |=> !flags_q[FL_TX]);               // R2
    AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !host_reset) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R3
    AST_RES_NEEDS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended && !flags_q[FL_RES]) |=> !flags_q[FL_RES]);              // R6
    AST_HRST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_reset && flags_q[FL_HRST]) |=> flags_q[FL_HRST]);              // R7
    AST_HRST_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        host_reset |=> (flags_q[FL_RES:FL_RX] == '0));                       // R7
endmodule

// File: rtl/usb_irq_status.sv
// Top of the USB device interrupt status logic: idle timer, suspended state
// and flag register, with one level interrupt output.
// Assumes all bus events arrive already decoded and synchronous to clk.
module usb_irq_status #(
    parameter int unsigned CLK_KHZ = 48000,
    parameter int unsigned IDLE_MS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] irq_mask,
    input  logic       rx_pkt_done,
    input  logic       tx_pkt_done,
    input  logic       bus_idle,
    input  logic       resume_seen,
    input  logic       host_reset,
    input  logic       reg_wr,
    input  logic [4:0] reg_wdata,
    output logic [4:0] reg_rdata,
    output logic       dev_suspended,
    output logic       irq
);
    import usbint_pkg::*;

    localparam int unsigned IDLE_LIMIT = CLK_KHZ * IDLE_MS + 1;

    logic             timeout;
    logic             susp;
    logic [NFLAG-1:0] flags;

    usbint_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_idle (bus_idle),
        .restart  (host_reset),
        .timeout  (timeout)
    );

    usbint_susp_state u_susp (
        .clk         (clk),
        .rst_n       (rst_n),
        .timeout     (timeout),
        .resume_seen (resume_seen),
        .host_reset  (host_reset),
        .suspended   (susp)
    );

    usbint_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask        (irq_mask),
        .rx_done     (rx_pkt_done),
        .tx_done     (tx_pkt_done),
        .timeout     (timeout),
        .suspended   (susp),
        .resume_seen (resume_seen),
        .host_reset  (host_reset),
        .wr_en       (reg_wr),
        .wr_data     (reg_wdata),
        .flags       (flags)
    );

    assign reg_rdata     = flags;
    assign dev_suspended = susp;
    assign irq           = |flags;

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr && !host_reset) |=> irq);                            // R8
endmodule

// File: tb/usb_irq_status_bench.sv
`timescale 1ns/1ps
module usb_irq_status_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] irq_mask;
    logic       rx_pkt_done, tx_pkt_done, bus_idle, resume_seen, host_reset, reg_wr;
    logic [4:0] reg_wdata;
    logic [4:0] reg_rdata;
    logic       dev_suspended, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam int THRESH = 4 * 3 + 1;   // idle cycles until the suspend flag sets

    always #2 clk = ~clk;                // 250 MHz

    usb_irq_status #(.CLK_KHZ(4), .IDLE_MS(3)) u_usb_irq_status (
        .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask),
        .rx_pkt_done(rx_pkt_done), .tx_pkt_done(tx_pkt_done),
        .bus_idle(bus_idle), .resume_seen(resume_seen), .host_reset(host_reset),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_suspended(dev_suspended), .irq(irq)
    );

    typedef struct packed {
        logic [4:0] mask;
        logic       rx;
        logic       tx;
        logic       we;
        logic [4:0] wd;
        logic [4:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{5'b00000, 1'b1, 1'b0, 1'b0, 5'b00000, 5'b00001},  // R1 rx sets bit 0
        '{5'b00000, 1'b0, 1'b1, 1'b0, 5'b00000, 5'b00011},  // R2 tx sets bit 1
        '{5'b00000, 1'b0, 1'b0, 1'b1, 5'b00001, 5'b00010},  // R3 clear bit 0 only
        '{5'b00000, 1'b0, 1'b0, 1'b1, 5'b00000, 5'b00010},  // R3 write zero no effect
        '{5'b00000, 1'b0, 1'b0, 1'b1, 5'b00010, 5'b00000},  // R3 clear bit 1
        '{5'b00001, 1'b1, 1'b0, 1'b0, 5'b00000, 5'b00000},  // R1 masked
        '{5'b00010, 1'b0, 1'b1, 1'b0, 5'b00000, 5'b00000},  // R2 masked
        '{5'b00000, 1'b1, 1'b0, 1'b1, 5'b00001, 5'b00001},  // R3 set beats clear
        '{5'b00000, 1'b0, 1'b0, 1'b1, 5'b11111, 5'b00000}   // R3 clear all
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_mask = '0; rx_pkt_done = 0; tx_pkt_done = 0;
        bus_idle = 0; resume_seen = 0; host_reset = 0; reg_wr = 0; reg_wdata = '0;
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        check("R9 reset flags", reg_rdata, 5'b0);
        check("R9 reset suspended", dev_suspended, 0);
        check("R8 reset irq", irq, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            irq_mask = VEC[i].mask; rx_pkt_done = VEC[i].rx; tx_pkt_done = VEC[i].tx;
            reg_wr = VEC[i].we; reg_wdata = VEC[i].wd;
            step();
            rx_pkt_done = 0; tx_pkt_done = 0; reg_wr = 0; reg_wdata = '0;
            check($sformatf("R10 vector %0d flags", i), reg_rdata, VEC[i].exp);
            check($sformatf("R8 vector %0d irq", i), irq, |VEC[i].exp);
        end
        irq_mask = '0;

        // R6: resume while not suspended does nothing
        resume_seen = 1; step(); resume_seen = 0;
        check("R6 resume not suspended", reg_rdata, 5'b0);

        // R4/R5: idle boundary
        bus_idle = 1;
        repeat (THRESH - 1) step();
        check("R4 one short of timeout", reg_rdata, 5'b0);
        check("R5 not yet suspended", dev_suspended, 0);
        step();
        check("R4 suspend flag at timeout", reg_rdata, 5'b00100);
        check("R5 suspended at timeout", dev_suspended, 1);
        reg_wr = 1; reg_wdata = 5'b00100; step(); reg_wr = 0; reg_wdata = '0;
        repeat (20) step();
        check("R4 fires once per idle period", reg_rdata, 5'b0);
        check("R5 stays suspended while idle", dev_suspended, 1);

        // R6: masked resume leaves suspend but sets nothing
        irq_mask = 5'b01000; bus_idle = 0; resume_seen = 1; step(); resume_seen = 0;
        irq_mask = '0;
        check("R6 masked resume", reg_rdata, 5'b0);
        check("R5 resume exits suspend", dev_suspended, 0);

        // Re-suspend, then unmasked resume
        bus_idle = 1;
        repeat (THRESH) step();
        check("R4 re-suspend after activity", reg_rdata, 5'b00100);
        reg_wr = 1; reg_wdata = 5'b00100; step(); reg_wr = 0; reg_wdata = '0;
        bus_idle = 0; resume_seen = 1; step(); resume_seen = 0;
        check("R6 resume while suspended", reg_rdata, 5'b01000);
        check("R5 exit after resume", dev_suspended, 0);

        // R7: host reset keeps only the reset flag
        rx_pkt_done = 1; step(); rx_pkt_done = 0;
        check("R1 rx alongside resume", reg_rdata, 5'b01001);
        host_reset = 1; step(); host_reset = 0;
        check("R7 host reset flags", reg_rdata, 5'b10000);
        check("R8 irq on reset flag alone", irq, 1);

        // R7: masked host reset while suspended keeps bit 4, clears suspend
        bus_idle = 1;
        repeat (THRESH) step();
        check("R7 suspended before host reset", reg_rdata, 5'b10100);
        irq_mask = 5'b10000; host_reset = 1; step(); host_reset = 0;
        bus_idle = 0; irq_mask = '0;
        check("R7 reset flag retained", reg_rdata, 5'b10000);
        check("R5 host reset exits suspend", dev_suspended, 0);

        // R3: write of zeros keeps bit 4
        reg_wr = 1; reg_wdata = 5'b00000; step(); reg_wr = 0;
        check("R3 zero write keeps bit 4", reg_rdata, 5'b10000);

        // R9: system reset clears the reset flag too
        rst_n = 0; step(); rst_n = 1;
        check("R9 system reset clears all", reg_rdata, 5'b0);
        check("R8 irq low after reset", irq, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule